// File: doc/BRIEF.md
# Next-Address Selector for a Single-Cycle Core

This block decides which address a single-cycle processor fetches after the current instruction. It is purely combinational. The decoder supplies a flow class code, and the register file supplies the two source operands. The current fetch address, the 26-bit jump target field and the 16-bit offset field come from the instruction. The block returns the selected next address, plus the sequential successor, which a link-type jump writes back into a register.

Three conditional branch kinds are resolved inside the block:

- branch-if-equal compares the two operands;
- branch-if-different compares the two operands;
- branch-if-negative looks only at the sign of the first operand.

Unconditional transfers cover three cases:

- a pseudo-direct jump, which keeps the top region bits of the successor and appends the target field;
- a jump to the address held in the first operand;
- a trap, which goes to a fixed handler vector set by a parameter.

Anything else falls through to the successor. The PC register and instruction memory live outside.

Top module: `next_pc_gen`

## Requirements
- R1: `incr_pc_o` always equals `pc_i + 4`, modulo 2^32, for every class code.
- R2: Class code 0 (sequential) and the unused code 7 give `next_pc_o = pc_i + 4`, whatever the operands and fields hold.
- R3: Class code 1 (branch-if-equal) gives the branch target when `rs_i == rt_i`, otherwise `pc_i + 4`.
- R4: Class code 2 (branch-if-different) gives the branch target when `rs_i != rt_i`, otherwise `pc_i + 4`.
- R5: Class code 3 (branch-if-negative) gives the branch target when `rs_i[31]` is 1, otherwise `pc_i + 4`. `rt_i` has no effect on this class.
- R6: The branch target is `pc_i + 4 + (sign-extended off_i << 2)`, modulo 2^32, so negative offsets move backward.
- R7: Class code 4 (pseudo-direct jump) gives `{(pc_i+4)[31:28], jta_i, 2'b00}`. The region bits come from the successor, not from `pc_i`.
- R8: Class code 5 (register jump) gives `rs_i` unchanged, including its low two bits.
- R9: Class code 6 (trap) gives the parameter `TRAP_VEC`, which defaults to 32'h0000_0180, regardless of every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| flow_i | input | 3 | Flow class code from the decoder (0 seq, 1 eq, 2 ne, 3 neg, 4 jump, 5 reg jump, 6 trap) |
| jta_i | input | 26 | Pseudo-direct jump target field |
| off_i | input | 16 | Signed branch offset in words |
| rs_i | input | 32 | First source operand |
| rt_i | input | 32 | Second source operand |
| next_pc_o | output | 32 | Selected next fetch address |
| incr_pc_o | output | 32 | Sequential successor, used as link value |

## Verification
Several corners are hard to reach with random stimulus alone:

- An address just below a 256 MB region boundary, where the successor carries into the region bits and so changes the upper bits of a pseudo-direct jump.
- Branch offsets that wrap the address space.
- An equality branch whose operands are truly equal.

Directed vectors place `pc_i` at 32'h0FFF_FFFC and 32'hFFFF_FFFC, and use the extreme offsets 16'h8000 and 16'h7FFF. The random stimulus copies `rs_i` into `rt_i` on about half of the branch vectors, so taken and not-taken outcomes of both comparisons occur often.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_BEQ  = 3'd1,
    FLOW_BNE  = 3'd2,
    FLOW_BLTZ = 3'd3,
    FLOW_JUMP = 3'd4,
    FLOW_JREG = 3'd5,
    FLOW_TRAP = 3'd6
  } flow_e;
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] pc_plus_o
);
  assign pc_plus_o = pc_i + ADDR_W'(STEP);
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  flow_e             flow_i,
  input  logic [ADDR_W-1:0] rs_i,
  input  logic [ADDR_W-1:0] rt_i,
  output logic              take_o
);
  logic same;
  assign same = (rs_i == rt_i);

  always_comb begin
    case (flow_i)
      FLOW_BEQ:  take_o = same;
      FLOW_BNE:  take_o = !same;
      FLOW_BLTZ: take_o = rs_i[ADDR_W-1];
      default:   take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int ADDR_W = 32,
  parameter int JTA_W  = 26,
  parameter int OFF_W  = 16,
  parameter int ALIGN  = 2
) (
  input  logic [ADDR_W-1:0] pc_plus_i,
  input  logic [JTA_W-1:0]  jta_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] br_tgt_o,
  output logic [ADDR_W-1:0] jmp_tgt_o
);
  localparam int EXT_W    = ADDR_W - OFF_W - ALIGN;
  localparam int REGION_W = ADDR_W - JTA_W - ALIGN;

  logic [ADDR_W-1:0] off_ext;
  assign off_ext  = {{EXT_W{off_i[OFF_W-1]}}, off_i, {ALIGN{1'b0}}};
  assign br_tgt_o = pc_plus_i + off_ext;

  generate
    if (REGION_W > 0) begin : g_region
      // region bits come from the successor address
      assign jmp_tgt_o = {pc_plus_i[ADDR_W-1 -: REGION_W], jta_i, {ALIGN{1'b0}}};
    end else begin : g_flat
      assign jmp_tgt_o = {jta_i[ADDR_W-ALIGN-1:0], {ALIGN{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/next_pc_gen.sv
module next_pc_gen
  import npc_pkg::*;
#(
  parameter int               ADDR_W     = 32,
  parameter int               JTA_W      = 26,
  parameter int               OFF_W      = 16,
  parameter int               INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] TRAP_VEC  = 32'h0000_0180
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [2:0]        flow_i,
  input  logic [JTA_W-1:0]  jta_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [ADDR_W-1:0] rs_i,
  input  logic [ADDR_W-1:0] rt_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic [ADDR_W-1:0] incr_pc_o
);
  localparam int ALIGN = $clog2(INSN_BYTES);

  flow_e             flow;
  logic              take;
  logic [ADDR_W-1:0] pc_plus, br_tgt, jmp_tgt;

  assign flow = flow_e'(flow_i);

  npc_incr #(.ADDR_W(ADDR_W), .STEP(INSN_BYTES)) incr_i (
    .pc_i      (pc_i),
    .pc_plus_o (pc_plus)
  );

  npc_cond #(.ADDR_W(ADDR_W)) cond_i (
    .flow_i (flow),
    .rs_i   (rs_i),
    .rt_i   (rt_i),
    .take_o (take)
  );

  npc_targets #(.ADDR_W(ADDR_W), .JTA_W(JTA_W), .OFF_W(OFF_W), .ALIGN(ALIGN)) tgt_i (
    .pc_plus_i (pc_plus),
    .jta_i     (jta_i),
    .off_i     (off_i),
    .br_tgt_o  (br_tgt),
    .jmp_tgt_o (jmp_tgt)
  );

  always_comb begin
    case (flow)
      FLOW_BEQ, FLOW_BNE, FLOW_BLTZ: next_pc_o = take ? br_tgt : pc_plus;
      FLOW_JUMP:                     next_pc_o = jmp_tgt;
      FLOW_JREG:                     next_pc_o = rs_i;
      FLOW_TRAP:                     next_pc_o = TRAP_VEC;
      default:                       next_pc_o = pc_plus;
    endcase
  end

  assign incr_pc_o = pc_plus;
endmodule

// File: rtl/next_pc_chk.sv
module next_pc_chk #(
  parameter int                ADDR_W   = 32,
  parameter int                JTA_W    = 26,
  parameter int                OFF_W    = 16,
  parameter logic [ADDR_W-1:0] TRAP_VEC = 32'h0000_0180
) (
  input logic [ADDR_W-1:0] pc_i,
  input logic [2:0]        flow_i,
  input logic [JTA_W-1:0]  jta_i,
  input logic [OFF_W-1:0]  off_i,
  input logic [ADDR_W-1:0] rs_i,
  input logic [ADDR_W-1:0] rt_i,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic [ADDR_W-1:0] incr_pc_o
);
  logic unused_fields;
  assign unused_fields = ^{jta_i, off_i};

  always_comb begin
    assert_incr_R1: assert (incr_pc_o - pc_i == ADDR_W'(4));
    if (flow_i == 3'd0 || flow_i == 3'd7)
      assert_seq_R2: assert (next_pc_o == incr_pc_o);
    if (flow_i == 3'd1 && rs_i != rt_i)
      assert_beq_fall_R3: assert (next_pc_o == incr_pc_o);
    if (flow_i == 3'd2 && rs_i == rt_i)
      assert_bne_fall_R4: assert (next_pc_o == incr_pc_o);
    if (flow_i == 3'd3 && !rs_i[ADDR_W-1])
      assert_bltz_fall_R5: assert (next_pc_o == incr_pc_o);
    if (flow_i == 3'd4)
      assert_jump_region_R7: assert (next_pc_o[ADDR_W-1 -: 4] == incr_pc_o[ADDR_W-1 -: 4]
                                     && next_pc_o[1:0] == 2'b00);
    if (flow_i == 3'd5)
      assert_jreg_R8: assert (next_pc_o == rs_i);
    if (flow_i == 3'd6)
      assert_trap_R9: assert (next_pc_o == TRAP_VEC);
  end
endmodule

bind next_pc_gen next_pc_chk #(
  .ADDR_W(ADDR_W), .JTA_W(JTA_W), .OFF_W(OFF_W), .TRAP_VEC(TRAP_VEC)
) chk_i (
  .pc_i(pc_i), .flow_i(flow_i), .jta_i(jta_i), .off_i(off_i),
  .rs_i(rs_i), .rt_i(rt_i), .next_pc_o(next_pc_o), .incr_pc_o(incr_pc_o)
);

// File: tb/next_pc_gen_tb_top.sv
module next_pc_gen_tb_top;
  logic        clk = 1'b0;
  logic [31:0] pc, rs, rt, next_pc, incr_pc;
  logic [2:0]  flow;
  logic [25:0] jta;
  logic [15:0] off;
  int          checks = 0;
  int          fails  = 0;
  int          cycles = 0;
  bit          done   = 0;

  always #2 clk = ~clk;

  next_pc_gen dut_i (
    .pc_i(pc), .flow_i(flow), .jta_i(jta), .off_i(off),
    .rs_i(rs), .rt_i(rt), .next_pc_o(next_pc), .incr_pc_o(incr_pc)
  );

  function automatic logic [31:0] exp_incr(input logic [31:0] p);
    return p + 32'd4;
  endfunction

  function automatic logic [31:0] exp_next(input logic [31:0] p, input logic [2:0] f,
                                           input logic [25:0] j, input logic [15:0] o,
                                           input logic [31:0] a, input logic [31:0] b);
    logic [31:0] s, bt;
    s  = p + 32'd4;
    bt = s + {{14{o[15]}}, o, 2'b00};
    case (f)
      3'd1: return (a == b) ? bt : s;
      3'd2: return (a != b) ? bt : s;
      3'd3: return a[31] ? bt : s;
      3'd4: return {s[31:28], j, 2'b00};
      3'd5: return a;
      3'd6: return 32'h0000_0180;
      default: return s;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] f);
    case (f)
      3'd1: return "R3/R6";
      3'd2: return "R4/R6";
      3'd3: return "R5/R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic apply(input logic [31:0] p, input logic [2:0] f, input logic [25:0] j,
                       input logic [15:0] o, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] en, ei;
    @(posedge clk);
    pc = p; flow = f; jta = j; off = o; rs = a; rt = b;
    @(negedge clk);
    en = exp_next(p, f, j, o, a, b);
    ei = exp_incr(p);
    checks++;
    if (incr_pc !== ei) begin
      fails++;
      $display("FAIL R1 incr_pc act=%h exp=%h", incr_pc, ei);
    end
    checks++;
    if (next_pc !== en) begin
      fails++;
      $display("FAIL %s flow=%0d next_pc act=%h exp=%h", tag(f), f, next_pc, en);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    pc = '0; flow = '0; jta = '0; off = '0; rs = '0; rt = '0;
    // R1 R2: sequential and unused code
    apply(32'h0000_0000, 3'd0, 26'h3FF_FFFF, 16'hFFFF, 32'h8000_0000, 32'h1);
    apply(32'hFFFF_FFFC, 3'd7, 26'h1, 16'h7FFF, 32'hFFFF_FFFF, 32'h0);
    // R3: equal taken / not taken
    apply(32'h0000_1000, 3'd1, '0, 16'h0004, 32'h55, 32'h55);
    apply(32'h0000_1000, 3'd1, '0, 16'h0004, 32'h55, 32'h54);
    // R4
    apply(32'h0000_2000, 3'd2, '0, 16'hFFFE, 32'h1, 32'h2);
    apply(32'h0000_2000, 3'd2, '0, 16'hFFFE, 32'h7, 32'h7);
    // R5: sign bit only, rt ignored
    apply(32'h0000_3000, 3'd3, '0, 16'h0010, 32'h8000_0000, 32'h8000_0000);
    apply(32'h0000_3000, 3'd3, '0, 16'h0010, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    // R6: extreme offsets and wrap
    apply(32'h0000_0000, 3'd1, '0, 16'h8000, 32'h0, 32'h0);
    apply(32'hFFFF_FFF8, 3'd1, '0, 16'h7FFF, 32'h0, 32'h0);
    // R7: region carry at boundary
    apply(32'h0FFF_FFFC, 3'd4, 26'h000_0001, '0, '0, '0);
    apply(32'hFFFF_FFFC, 3'd4, 26'h3FF_FFFF, '0, '0, '0);
    apply(32'h0FFF_FFF8, 3'd4, 26'h2AA_AAAA, '0, '0, '0);
    // R8: low bits preserved
    apply(32'h0000_4000, 3'd5, '0, '0, 32'hDEAD_BEEF, 32'h0);
    // R9
    apply(32'h1234_5678, 3'd6, 26'h3FF_FFFF, 16'h8000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom % 2) ? a : $urandom;
      apply($urandom, 3'($urandom % 8), 26'($urandom), 16'($urandom), a, b);
    end
    done = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=%0d exp<=100000", cycles);
      done = 1;
    end
  end

  initial begin
    wait (done);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule